// File: doc/BRIEF.md
# Binary64 Grid Residue Unit

This block takes one IEEE-754 binary64 operand and returns what is left after the operand is snapped to a grid of spacing 2^-M. It first rounds the value to a multiple of 2^-M, then subtracts that multiple from the operand, and returns the difference as a binary64 number. The grid exponent M and the rounding behaviour come from an 8-bit control byte. A core-wide rounding mode and a core-wide precision-exception mask can take the place of the byte's own settings. Typical uses are argument reduction before a polynomial kernel and splitting a value into coarse and fine parts.

Control byte layout: bits [7:4] hold M, an unsigned value from 0 to 15. Bit [3] suppresses the precision flag. Bit [2] selects the global rounding mode in place of bits [1:0]. Bits [1:0] hold the local rounding mode.

Rounding mode encoding, used by both the local field and the global input:
- 00: nearest, ties to even.
- 01: toward minus infinity.
- 10: toward plus infinity.
- 11: toward zero.

The result and both flags are registered, so each is valid one clock after its operands are presented. A new operand can be accepted every cycle.

Top module: `fpr_reduce_unit`

## Requirements
- R1: Outputs are registered, with one cycle of latency from operands to result. While `rst_n` is low, `res_o`, `invalid_o` and `precision_o` are all zero.
- R2: For a finite nonzero input, `res_o` equals src − Q·2^-M, where M = `ctl_i[7:4]`. Q is 2^M·src rounded to an integer under the effective mode: 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero.
- R3: When `ctl_i[2]`=1 the effective mode is `glob_rm_i`; when `ctl_i[2]`=0 it is `ctl_i[1:0]`, and `glob_rm_i` has no effect.
- R4: `precision_o` is 1 only when the delivered result is inexact, `ctl_i[3]`=0 and `pe_mask_i`=0. Setting either `ctl_i[3]` or `pe_mask_i` forces it to 0.
- R5: A NaN input returns the same sign and payload with significand bit 51 set. `invalid_o` is 1 exactly when that bit was 0 on the input, i.e. for a signaling NaN.
- R6: An input of ±infinity returns +0.0 (all bits zero) under every mode, with both flags 0.
- R7: An input of ±0, or an exactly zero residue from a finite input, returns −0.0 (only bit 63 set) when the effective mode is 01 and +0.0 for every other mode.
- R8: When |src| < 2^(-M-1) under mode 00, when 0 ≤ src < 2^-M under mode 01, and when −2^-M < src ≤ 0 under mode 10, the input is returned unchanged with no precision flag.
- R9: When 0 < src < 2^-M under mode 10, the result is src − 2^-M. When −2^-M < src < 0 under mode 01, the result is src + 2^-M. In both cases the difference is rounded under the same mode and raises the precision condition when it is inexact.
- R10: When the input's unbiased exponent is at least 52 − M, the result is an exact zero that follows R7, with `precision_o`=0.
- R11: Subnormal inputs are treated as their true values, with no flush to zero. They are either returned unchanged or shifted by one grid step as in R8 and R9.
- R12: For every finite input, |result| < 2^-M. Under mode 00 the bound tightens to |result| ≤ 2^(-M-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Binary64 operand |
| ctl_i | input | 8 | Control byte: [7:4] M, [3] suppress precision flag, [2] use global mode, [1:0] local mode |
| glob_rm_i | input | 2 | Global rounding mode, same encoding as `ctl_i[1:0]` |
| pe_mask_i | input | 1 | Global precision-exception mask; 1 masks the flag |
| res_o | output | 64 | Binary64 residue |
| invalid_o | output | 1 | Invalid flag, set for a signaling NaN input |
| precision_o | output | 1 | Precision (inexact) flag |

## Verification
The bench drives exact ties such as 1.5 and 2.5 at M=0. A design that rounds ties away from zero, or that reads the wrong bit as the quotient's low bit at the top of the significand, returns a residue with the wrong sign. It sends operands just below one grid step under directed rounding, including subnormals and 2^-60. This catches a design that returns the operand unchanged, drops the sticky bits of the long subtraction, or rounds the difference the wrong way. Signed-zero inputs and exact-zero residues check the sign that depends on round-down, infinities check the +0 result, and quiet and signaling NaNs check quieting and the invalid flag. Applying the two precision-suppression controls one at a time catches a flag that ignores either control.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned MAN_W  = 52;
  localparam int unsigned SIG_W  = MAN_W + 1;
  localparam int unsigned FP_W   = 1 + EXP_W + MAN_W;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned SH_W   = EXP_W + 2;
  localparam int unsigned WIN_W  = 2 * SIG_W + 2;
  localparam int unsigned CNT_W  = $clog2(SIG_W + 1);
  localparam int unsigned MW     = 4;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpr_lzc.sv
module fpr_lzc #(
  parameter int unsigned W  = 53,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // Highest set bit wins because later iterations overwrite earlier ones.
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) cnt_o = CW'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/fpr_near.sv
// Residue when the grid cuts inside the significand (1 <= shift <= 53).
// The residue is exact and always lands in the normal range.
module fpr_near
  import fpr_pkg::*;
(
  input  logic             sign_i,
  input  logic [EXP_W-1:0] eeff_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [5:0]       sh_i,
  input  rmode_e           rm_i,
  output logic             zero_o,
  output logic [FP_W-1:0]  res_o
);
  logic [SIG_W-1:0] pow, lo, half, mag, norm;
  logic             qlsb, up;
  logic [CNT_W-1:0] lzc;
  logic [EXP_W-1:0] rexp;

  always_comb begin
    pow  = SIG_W'(1) << sh_i;
    half = SIG_W'(1) << (sh_i - 6'd1);
    lo   = sig_i & (pow - SIG_W'(1));
    qlsb = |(sig_i & pow);
    unique case (rm_i)
      RM_NEAR: up = (lo > half) || ((lo == half) && qlsb);
      RM_DOWN: up = sign_i && (lo != '0);
      RM_UP:   up = !sign_i && (lo != '0);
      default: up = 1'b0;
    endcase
    // Modulo-2^53 subtraction is exact because the residue stays below 2^53.
    mag = up ? (pow - lo) : lo;
  end

  fpr_lzc #(.W(SIG_W), .CW(CNT_W)) lzc_i (
    .vec_i (mag),
    .cnt_o (lzc)
  );

  always_comb begin
    norm   = mag << lzc;
    rexp   = eeff_i - EXP_W'(lzc);
    zero_o = (mag == '0);
    res_o  = {sign_i ^ up, rexp, norm[MAN_W-1:0]};
  end
endmodule

// File: rtl/fpr_far.sv
// Operand lies entirely below the grid and moves one full step toward zero
// on the opposite side. The difference points against the direction of the
// rounding mode, so rounding only truncates. A window of 2*SIG_W+2 bits
// carries the whole significand, the guard bit and a nonzero sticky tail.
module fpr_far
  import fpr_pkg::*;
(
  input  logic              sign_i,
  input  logic signed [SH_W-1:0] sh_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [MW-1:0]     m_i,
  output logic [FP_W-1:0]   res_o,
  output logic              inexact_o
);
  localparam logic [6:0] WIN = 7'(WIN_W);

  logic [6:0]       shc;
  logic [WIN_W-1:0] diff, win;

  always_comb begin
    shc  = (sh_i > SH_W'($signed({1'b0, WIN}))) ? WIN : sh_i[6:0];
    // 2^shc - sig modulo 2^WIN_W: exact, because sig is nonzero.
    diff = (WIN_W'(1) << shc) - WIN_W'(sig_i);
    win  = diff << (WIN - shc);
    inexact_o = |win[WIN_W-SIG_W-1:0];
    res_o = {~sign_i,
             win[WIN_W-1] ? (EXP_W'(BIAS - 1) - EXP_W'(m_i)) : '0,
             win[WIN_W-2 -: MAN_W]};
  end
endmodule

// File: rtl/fpr_reduce_unit.sv
module fpr_reduce_unit
  import fpr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_i,
  input  logic [7:0]  ctl_i,
  input  logic [1:0]  glob_rm_i,
  input  logic        pe_mask_i,
  output logic [63:0] res_o,
  output logic        invalid_o,
  output logic        precision_o
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam int unsigned      SH_OFF   = BIAS + MAN_W;

  logic                   sign, is_nan, is_inf, is_zero, tiny_up;
  logic [EXP_W-1:0]       ex, eeff;
  logic [SIG_W-1:0]       sig;
  logic [MW-1:0]          m;
  logic signed [SH_W-1:0] sh;
  rmode_e                 rm_sel;
  logic [FP_W-1:0]        zero_res, near_res, far_res;
  logic                   near_zero, far_inexact;

  logic [FP_W-1:0] res_d;
  logic            inv_d, inexact_d, pe_d;

  always_comb begin
    sign    = src_i[FP_W-1];
    ex      = src_i[FP_W-2 -: EXP_W];
    m       = ctl_i[7:4];
    rm_sel  = rmode_e'(ctl_i[2] ? glob_rm_i : ctl_i[1:0]);
    is_nan  = (ex == EXP_ONES) && (src_i[MAN_W-1:0] != '0);
    is_inf  = (ex == EXP_ONES) && (src_i[MAN_W-1:0] == '0);
    is_zero = (ex == '0) && (src_i[MAN_W-1:0] == '0);
    eeff    = (ex == '0) ? EXP_W'(1) : ex;
    sig     = {ex != '0, src_i[MAN_W-1:0]};
    // Count of significand bits lying below the 2^-M grid position.
    sh      = SH_W'($signed(SH_OFF)) - $signed({2'b0, eeff}) - $signed({{(SH_W-MW){1'b0}}, m});
    zero_res = {rm_sel == RM_DOWN, {(FP_W-1){1'b0}}};
    tiny_up  = ((rm_sel == RM_UP) && !sign) || ((rm_sel == RM_DOWN) && sign);
  end

  fpr_near near_i (
    .sign_i (sign),
    .eeff_i (eeff),
    .sig_i  (sig),
    .sh_i   (sh[5:0]),
    .rm_i   (rm_sel),
    .zero_o (near_zero),
    .res_o  (near_res)
  );

  fpr_far far_i (
    .sign_i    (sign),
    .sh_i      (sh),
    .sig_i     (sig),
    .m_i       (m),
    .res_o     (far_res),
    .inexact_o (far_inexact)
  );

  // Next-state selection.
  always_comb begin
    res_d     = src_i;
    inv_d     = 1'b0;
    inexact_d = 1'b0;
    if (is_nan) begin
      res_d = {sign, EXP_ONES, 1'b1, src_i[MAN_W-2:0]};
      inv_d = ~src_i[MAN_W-1];
    end else if (is_inf) begin
      res_d = '0;
    end else if (is_zero || (sh <= SH_W'(0))) begin
      res_d = zero_res;
    end else if (sh <= SH_W'($signed(SIG_W))) begin
      res_d = near_zero ? zero_res : near_res;
    end else if (tiny_up) begin
      res_d     = far_res;
      inexact_d = far_inexact;
    end
    pe_d = inexact_d && !ctl_i[3] && !pe_mask_i;
  end

  // Result register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o       <= '0;
      invalid_o   <= 1'b0;
      precision_o <= 1'b0;
    end else begin
      res_o       <= res_d;
      invalid_o   <= inv_d;
      precision_o <= pe_d;
    end
  end

  assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_nan |=> (res_o[62:51] == 12'hFFF && res_o[50:0] == $past(src_i[50:0])
                && invalid_o == !$past(src_i[51])));

  assert_inf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_inf |=> (res_o == 64'd0 && !invalid_o && !precision_o));

  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_zero |=> (res_o == {$past(rm_sel == RM_DOWN), 63'd0}));

  assert_pe_suppress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[3] || pe_mask_i) |=> !precision_o);

  assert_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nan && !is_inf) |=> (res_o[62:52] <= (11'd1022 - 11'($past(ctl_i[7:4])))));

  assert_near_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nan && !is_inf && rm_sel == RM_NEAR) |=>
      ((res_o[62:52] < (11'd1022 - 11'($past(ctl_i[7:4])))) || (res_o[51:0] == 52'd0)));
endmodule

// File: tb/fpr_reduce_unit_tb.sv
module fpr_reduce_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic [7:0]  ctl_i;
  logic [1:0]  glob_rm_i;
  logic        pe_mask_i;
  logic [63:0] res_o;
  logic        invalid_o, precision_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fpr_reduce_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ctl_i(ctl_i),
    .glob_rm_i(glob_rm_i), .pe_mask_i(pe_mask_i),
    .res_o(res_o), .invalid_o(invalid_o), .precision_o(precision_o)
  );

  function automatic logic [63:0] b(input real r);
    return $realtobits(r);
  endfunction

  task automatic expect_out(input string tag, input logic [63:0] er,
                            input logic ei, input logic ep);
    checks++;
    if (res_o !== er || invalid_o !== ei || precision_o !== ep) begin
      fails++;
      $display("FAIL %s: got res=%h inv=%b pe=%b expected res=%h inv=%b pe=%b",
               tag, res_o, invalid_o, precision_o, er, ei, ep);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] s, input logic [7:0] c,
                     input logic [1:0] g, input logic mk,
                     input logic [63:0] er, input logic ei, input logic ep);
    @(negedge clk);
    src_i = s; ctl_i = c; glob_rm_i = g; pe_mask_i = mk;
    @(negedge clk);
    expect_out(tag, er, ei, ep);
  endtask

  task automatic t_reset;  // R1
    rst_n = 1'b0; src_i = b(2.75); ctl_i = 8'h12; glob_rm_i = 2'b00; pe_mask_i = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 64'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;  // R1
    run("R1 first", b(1.5), 8'h00, 2'b00, 1'b0, b(-0.5), 1'b0, 1'b0);
    @(negedge clk);
    src_i = b(2.5);
    #1 expect_out("R1 held before edge", b(-0.5), 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R1 one cycle", b(0.5), 1'b0, 1'b0);
  endtask

  task automatic t_modes;  // R2
    run("R2 rne", b(2.75), 8'h10, 2'b00, 1'b0, b(-0.25), 1'b0, 1'b0);
    run("R2 down", b(2.75), 8'h11, 2'b00, 1'b0, b(0.25), 1'b0, 1'b0);
    run("R2 up", b(2.75), 8'h12, 2'b00, 1'b0, b(-0.25), 1'b0, 1'b0);
    run("R2 zero", b(2.75), 8'h13, 2'b00, 1'b0, b(0.25), 1'b0, 1'b0);
    run("R2 neg zero", b(-2.75), 8'h13, 2'b00, 1'b0, b(-0.25), 1'b0, 1'b0);
    run("R2 neg down", b(-2.75), 8'h11, 2'b00, 1'b0, b(0.25), 1'b0, 1'b0);
    run("R2 neg rne", b(-2.75), 8'h10, 2'b00, 1'b0, b(0.25), 1'b0, 1'b0);
    run("R2 tie odd", b(1.5), 8'h00, 2'b00, 1'b0, b(-0.5), 1'b0, 1'b0);
    run("R2 tie even", b(2.5), 8'h00, 2'b00, 1'b0, b(0.5), 1'b0, 1'b0);
    run("R2 top bit", b(0.375), 8'h10, 2'b00, 1'b0, b(-0.125), 1'b0, 1'b0);
    run("R2 m15", b(1.0 + 2.0 ** -20.0), 8'hF0, 2'b00, 1'b0, b(2.0 ** -20.0), 1'b0, 1'b0);
  endtask

  task automatic t_global;  // R3
    run("R3 glob down", b(2.75), 8'h14, 2'b01, 1'b0, b(0.25), 1'b0, 1'b0);
    run("R3 glob up", b(2.75), 8'h14, 2'b10, 1'b0, b(-0.25), 1'b0, 1'b0);
    run("R3 glob ignored", b(2.75), 8'h11, 2'b10, 1'b0, b(0.25), 1'b0, 1'b0);
  endtask

  task automatic t_precision;  // R4
    run("R4 raised", b(2.0 ** -60.0), 8'h02, 2'b00, 1'b0, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b1);
    run("R4 byte suppress", b(2.0 ** -60.0), 8'h0A, 2'b00, 1'b0, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b0);
    run("R4 mask", b(2.0 ** -60.0), 8'h02, 2'b00, 1'b1, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b0);
    run("R4 via global", b(2.0 ** -60.0), 8'h06, 2'b10, 1'b0, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b1);
  endtask

  task automatic t_nan;  // R5
    run("R5 qnan", 64'h7FF8000000000001, 8'h00, 2'b00, 1'b0, 64'h7FF8000000000001, 1'b0, 1'b0);
    run("R5 snan", 64'h7FF0000000000001, 8'h11, 2'b00, 1'b0, 64'h7FF8000000000001, 1'b1, 1'b0);
    run("R5 neg snan", 64'hFFF0000000000005, 8'h02, 2'b00, 1'b0, 64'hFFF8000000000005, 1'b1, 1'b0);
  endtask

  task automatic t_inf;  // R6
    run("R6 +inf down", 64'h7FF0000000000000, 8'h01, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
    run("R6 -inf rne", 64'hFFF0000000000000, 8'h00, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_zero;  // R7
    run("R7 +0 rne", 64'd0, 8'h00, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
    run("R7 +0 down", 64'd0, 8'h01, 2'b00, 1'b0, 64'h8000000000000000, 1'b0, 1'b0);
    run("R7 -0 up", 64'h8000000000000000, 8'h02, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
    run("R7 exact down", b(3.0), 8'h01, 2'b00, 1'b0, 64'h8000000000000000, 1'b0, 1'b0);
    run("R7 exact up", b(3.0), 8'h02, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
    run("R7 neg exact rne", b(-3.0), 8'h00, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_coarse;  // R10
    run("R10 big rne", b(9007199254740994.0), 8'h00, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
    run("R10 big down", b(9007199254740994.0), 8'h01, 2'b00, 1'b0, 64'h8000000000000000, 1'b0, 1'b0);
    run("R10 m15", b(-(2.0 ** 40.0)), 8'hF2, 2'b00, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_tiny_keep;  // R8
    run("R8 rne small", b(0.1), 8'h20, 2'b00, 1'b0, b(0.1), 1'b0, 1'b0);
    run("R8 down pos", b(0.2), 8'h21, 2'b00, 1'b0, b(0.2), 1'b0, 1'b0);
    run("R8 up neg", b(-0.2), 8'h22, 2'b00, 1'b0, b(-0.2), 1'b0, 1'b0);
  endtask

  task automatic t_tiny_shift;  // R9
    run("R9 up exact", b(0.125), 8'h22, 2'b00, 1'b0, b(-0.125), 1'b0, 1'b0);
    run("R9 up m0", b(2.0 ** -60.0), 8'h02, 2'b00, 1'b0, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b1);
    run("R9 down neg", b(-(2.0 ** -60.0)), 8'h01, 2'b00, 1'b0, 64'h3FEFFFFFFFFFFFFF, 1'b0, 1'b1);
    run("R9 up m4", b(2.0 ** -60.0), 8'h42, 2'b00, 1'b0, 64'hBFAFFFFFFFFFFFFF, 1'b0, 1'b1);
  endtask

  task automatic t_subnormal;  // R11
    run("R11 min rne", 64'h1, 8'h00, 2'b00, 1'b0, 64'h1, 1'b0, 1'b0);
    run("R11 min up", 64'h1, 8'h02, 2'b00, 1'b0, 64'hBFEFFFFFFFFFFFFF, 1'b0, 1'b1);
    run("R11 max down", 64'h000FFFFFFFFFFFFF, 8'h01, 2'b00, 1'b0, 64'h000FFFFFFFFFFFFF, 1'b0, 1'b0);
    run("R11 neg max down", 64'h800FFFFFFFFFFFFF, 8'h01, 2'b00, 1'b0, 64'h3FEFFFFFFFFFFFFF, 1'b0, 1'b1);
  endtask

  task automatic t_bound;  // R12
    real vals [4] = '{2.75, -7.3, 0.001, 123.456};
    int  ms   [3] = '{0, 3, 9};
    foreach (vals[vi]) begin
      foreach (ms[mi]) begin
        for (int r = 0; r < 4; r++) begin
          real lim, got;
          @(negedge clk);
          src_i = b(vals[vi]); ctl_i = {4'(ms[mi]), 2'b00, 2'(r)};
          glob_rm_i = 2'b00; pe_mask_i = 1'b0;
          @(negedge clk);
          got = $bitstoreal(res_o);
          if (got < 0.0) got = -got;
          lim = (r == 0) ? 2.0 ** real'(-ms[mi] - 1) : 2.0 ** real'(-ms[mi]);
          checks++;
          if ((r == 0 && got > lim) || (r != 0 && got >= lim)) begin
            fails++;
            $display("FAIL R12 bound: src=%f m=%0d mode=%0d got |res|=%e expected limit %e",
                     vals[vi], ms[mi], r, got, lim);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_modes();
    t_global();
    t_precision();
    t_nan();
    t_inf();
    t_zero();
    t_coarse();
    t_tiny_keep();
    t_tiny_shift();
    t_subnormal();
    t_bound();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule